// File: doc/BRIEF.md
# Open-Row-Aware Command Arbiter

The arbiter sits in front of a DRAM command bus. Each of N masters may offer one candidate command per cycle. A candidate is a read or a write to a bank and row, and it carries a priority and an age stamp. The stamp comes from a free-running counter at enqueue time. The arbiter keeps a small table that holds, for each bank, whether a row is open and which row it is. Each cycle it picks one candidate. It then issues that candidate's read or write if its row is already open. Otherwise it issues the row command that brings the candidate closer to a hit: a precharge if a different row is open in that bank, or an activate if the bank is closed.

A master whose candidate is not yet a hit simply keeps requesting. The precharge, activate and final access then appear on successive decisions without any sequencer. Only the cycle that issues the read or write returns a grant to the master. DRAM timing, refresh and data movement are handled elsewhere.

Top module: `row_arb`

## Requirements
- R1: After reset all banks are closed and the outputs show op NOP (code 0), an all-zero grant, and bank and row zero.
- R2: A cycle with no request bit set produces op NOP and an all-zero grant on the next cycle.
- R3: A valid candidate whose bank is open on its own row (a hit) is selected over every non-hit candidate, whatever their priorities. This holds for reads and for writes alike.
- R4: Among hit candidates, the one with the largest priority value is selected.
- R5: Among selected-class candidates of equal priority, the oldest is selected. Stamp a is older than stamp b when bit AGE_W-1 of (a - b) modulo 2^AGE_W is set.
- R6: Candidates equal in hit status, priority and age resolve to the lowest master index.
- R7: When the selected candidate is a hit, the next cycle shows op RD (3) if its rd bit is 1 or WR (4) if it is 0. That cycle also shows its bank and row and a one-hot grant on its index for that one decision. The grant is never set for any other op.
- R8: When the selected candidate misses and its bank holds a different open row, the next cycle shows op PRE (2) with that bank and the row being closed, and no grant. The bank is closed afterwards.
- R9: When the selected candidate misses and its bank is closed, the next cycle shows op ACT (1) with the candidate's bank and row, and no grant. That row is open afterwards.
- R10: When no candidate hits, the selection among all valid candidates uses the largest priority, then the oldest stamp, then the lowest index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | N_MST | Candidate valid per master |
| rd_i | input | N_MST | 1 = read, 0 = write, per master |
| bank_i | input | N_MST*BANK_W | Bank per master, master i at bits [i*BANK_W +: BANK_W] |
| row_i | input | N_MST*ROW_W | Row per master, packed the same way |
| prio_i | input | N_MST*PRIO_W | Priority per master, larger wins |
| age_i | input | N_MST*AGE_W | Enqueue stamp per master |
| gnt_o | output | N_MST | One-hot grant for an issued read or write |
| op_o | output | 3 | Issued op: 0 NOP, 1 ACT, 2 PRE, 3 RD, 4 WR |
| bank_o | output | BANK_W | Bank of the issued op |
| row_o | output | ROW_W | Row of the issued op |

## Verification
Each decision is registered once, so the op, bank, row and grant for the inputs present before a rising edge appear just after that edge. The open-row table is updated at the same edge, and its effect shows on the decision made at the following edge. The bench drives inputs one time unit after a rising edge and computes the expected result from its own copy of the table. It then samples one time unit after the next rising edge, which is exactly one register stage later. Directed sequences walk through activate, precharge and hit paths, and through priority, age-wrap and index ties. Random traffic is drawn from a narrow row and age range so that hits and ties come up often.

// File: rtl/row_arb_pkg.sv
package row_arb_pkg;
  typedef enum logic [2:0] {
    OP_NOP = 3'd0,
    OP_ACT = 3'd1,
    OP_PRE = 3'd2,
    OP_RD  = 3'd3,
    OP_WR  = 3'd4
  } op_e;
endpackage

// File: rtl/row_arb_table.sv
module row_arb_table #(
  parameter int N_BANK = 4,
  parameter int ROW_W  = 13,
  localparam int BANK_W = $clog2(N_BANK)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  row_arb_pkg::op_e      upd_op_i,
  input  logic [BANK_W-1:0]     upd_bank_i,
  input  logic [ROW_W-1:0]      upd_row_i,
  output logic [N_BANK-1:0]     vld_o,
  output logic [ROW_W-1:0]      row_o [N_BANK]
);
  import row_arb_pkg::*;

  for (genvar b = 0; b < N_BANK; b++) begin : g_bank
    logic sel;
    assign sel = (upd_bank_i == BANK_W'(b));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_o[b] <= 1'b0;
        row_o[b] <= '0;
      end else if (sel && upd_op_i == OP_PRE) begin
        vld_o[b] <= 1'b0;
      end else if (sel && upd_op_i == OP_ACT) begin
        vld_o[b] <= 1'b1;
        row_o[b] <= upd_row_i;
      end
    end
  end
endmodule

// File: rtl/row_arb_pick.sv
module row_arb_pick #(
  parameter int N_MST  = 4,
  parameter int N_BANK = 4,
  parameter int ROW_W  = 13,
  parameter int PRIO_W = 3,
  parameter int AGE_W  = 8,
  localparam int BANK_W = $clog2(N_BANK),
  localparam int IDX_W  = $clog2(N_MST)
) (
  input  logic [N_MST-1:0]        req_i,
  input  logic [N_MST*BANK_W-1:0] bank_i,
  input  logic [N_MST*ROW_W-1:0]  row_i,
  input  logic [N_MST*PRIO_W-1:0] prio_i,
  input  logic [N_MST*AGE_W-1:0]  age_i,
  input  logic [N_BANK-1:0]       tbl_vld_i,
  input  logic [ROW_W-1:0]        tbl_row_i [N_BANK],
  output logic                    any_o,
  output logic [IDX_W-1:0]        sel_o,
  output logic                    sel_hit_o
);
  logic [N_MST-1:0] hit;
  logic [PRIO_W-1:0] prio [N_MST];
  logic [AGE_W-1:0]  age  [N_MST];

  for (genvar i = 0; i < N_MST; i++) begin : g_hit
    logic [BANK_W-1:0] b;
    assign b       = bank_i[i*BANK_W +: BANK_W];
    assign prio[i] = prio_i[i*PRIO_W +: PRIO_W];
    assign age[i]  = age_i[i*AGE_W +: AGE_W];
    assign hit[i]  = tbl_vld_i[b] && (tbl_row_i[b] == row_i[i*ROW_W +: ROW_W]);
  end

  function automatic logic older(input logic [AGE_W-1:0] a, input logic [AGE_W-1:0] b);
    logic [AGE_W-1:0] d;
    d = a - b;
    return d[AGE_W-1];
  endfunction

  // Lexicographic key: hit, then priority, then age; strict compare keeps lowest index
  always_comb begin
    logic [IDX_W-1:0] best;
    logic found;
    best  = '0;
    found = 1'b0;
    for (int i = 0; i < N_MST; i++) begin
      if (req_i[i]) begin
        if (!found
            || (hit[i] && !hit[best])
            || (hit[i] == hit[best] && prio[i] > prio[best])
            || (hit[i] == hit[best] && prio[i] == prio[best] && older(age[i], age[best]))) begin
          best  = IDX_W'(i);
          found = 1'b1;
        end
      end
    end
    any_o     = found;
    sel_o     = best;
    sel_hit_o = found && hit[best];
  end
endmodule

// File: rtl/row_arb.sv
module row_arb #(
  parameter int N_MST  = 4,
  parameter int N_BANK = 4,
  parameter int ROW_W  = 13,
  parameter int PRIO_W = 3,
  parameter int AGE_W  = 8,
  localparam int BANK_W = $clog2(N_BANK),
  localparam int IDX_W  = $clog2(N_MST)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [N_MST-1:0]        req_i,
  input  logic [N_MST-1:0]        rd_i,
  input  logic [N_MST*BANK_W-1:0] bank_i,
  input  logic [N_MST*ROW_W-1:0]  row_i,
  input  logic [N_MST*PRIO_W-1:0] prio_i,
  input  logic [N_MST*AGE_W-1:0]  age_i,
  output logic [N_MST-1:0]        gnt_o,
  output logic [2:0]              op_o,
  output logic [BANK_W-1:0]       bank_o,
  output logic [ROW_W-1:0]        row_o
);
  import row_arb_pkg::*;

  logic [N_BANK-1:0] tbl_vld;
  logic [ROW_W-1:0]  tbl_row [N_BANK];
  logic              any, sel_hit;
  logic [IDX_W-1:0]  sel;
  op_e               nxt_op;
  logic [N_MST-1:0]  nxt_gnt;
  logic [BANK_W-1:0] nxt_bank;
  logic [ROW_W-1:0]  nxt_row;

  row_arb_pick #(
    .N_MST(N_MST), .N_BANK(N_BANK), .ROW_W(ROW_W), .PRIO_W(PRIO_W), .AGE_W(AGE_W)
  ) u_pick (
    .req_i(req_i), .bank_i(bank_i), .row_i(row_i), .prio_i(prio_i), .age_i(age_i),
    .tbl_vld_i(tbl_vld), .tbl_row_i(tbl_row),
    .any_o(any), .sel_o(sel), .sel_hit_o(sel_hit)
  );

  always_comb begin
    nxt_op   = OP_NOP;
    nxt_gnt  = '0;
    nxt_bank = '0;
    nxt_row  = '0;
    if (any) begin
      nxt_bank = bank_i[sel*BANK_W +: BANK_W];
      nxt_row  = row_i[sel*ROW_W +: ROW_W];
      if (sel_hit) begin
        nxt_op       = rd_i[sel] ? OP_RD : OP_WR;
        nxt_gnt[sel] = 1'b1;
      end else if (tbl_vld[nxt_bank]) begin
        nxt_op  = OP_PRE;
        nxt_row = tbl_row[nxt_bank];  // report the row being closed
      end else begin
        nxt_op  = OP_ACT;
      end
    end
  end

  row_arb_table #(.N_BANK(N_BANK), .ROW_W(ROW_W)) u_tbl (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .upd_op_i(nxt_op), .upd_bank_i(nxt_bank), .upd_row_i(nxt_row),
    .vld_o(tbl_vld), .row_o(tbl_row)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gnt_o  <= '0;
      op_o   <= OP_NOP;
      bank_o <= '0;
      row_o  <= '0;
    end else begin
      gnt_o  <= nxt_gnt;
      op_o   <= nxt_op;
      bank_o <= nxt_bank;
      row_o  <= nxt_row;
    end
  end

  // R7
  gnt_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o));
  // R7
  gnt_op_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|gnt_o) |-> (op_o == OP_RD || op_o == OP_WR));
  // R7
  gnt_row_open_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|gnt_o) |-> (tbl_vld[bank_o] && tbl_row[bank_o] == row_o));
  // R2
  idle_nop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|req_i) |=> (op_o == OP_NOP && gnt_o == '0));
  // R9
  act_opens_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_o == OP_ACT) |-> (tbl_vld[bank_o] && tbl_row[bank_o] == row_o && gnt_o == '0));
  // R8
  pre_closes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_o == OP_PRE) |-> (!tbl_vld[bank_o] && gnt_o == '0));
endmodule

// File: tb/tb_row_arb.sv
`timescale 1ns/1ps
module tb_row_arb;
  localparam int N = 4, NB = 4, BW = 2, RW = 13, PW = 3, AW = 8;

  logic clk = 0, rst_n = 0;
  always #2.5 clk = ~clk;

  logic [N-1:0] req_f, rd_f, gnt;
  logic [N*BW-1:0] bank_f;
  logic [N*RW-1:0] row_f;
  logic [N*PW-1:0] prio_f;
  logic [N*AW-1:0] age_f;
  logic [2:0] op;
  logic [BW-1:0] bank;
  logic [RW-1:0] row;

  logic          m_req [N], m_rd [N];
  logic [BW-1:0] m_bank [N];
  logic [RW-1:0] m_row [N];
  logic [PW-1:0] m_prio [N];
  logic [AW-1:0] m_age [N];

  always_comb
    for (int i = 0; i < N; i++) begin
      req_f[i] = m_req[i];
      rd_f[i]  = m_rd[i];
      bank_f[i*BW +: BW] = m_bank[i];
      row_f[i*RW +: RW]  = m_row[i];
      prio_f[i*PW +: PW] = m_prio[i];
      age_f[i*AW +: AW]  = m_age[i];
    end

  row_arb dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req_f), .rd_i(rd_f), .bank_i(bank_f),
    .row_i(row_f), .prio_i(prio_f), .age_i(age_f),
    .gnt_o(gnt), .op_o(op), .bank_o(bank), .row_o(row)
  );

  int checks = 0, errors = 0;
  logic          tv [NB];
  logic [RW-1:0] tr [NB];

  function automatic bit older(input logic [AW-1:0] a, input logic [AW-1:0] b);
    logic [AW-1:0] d;
    d = a - b;
    return d[AW-1];
  endfunction

  function automatic bit is_hit(input int i);
    return tv[m_bank[i]] && tr[m_bank[i]] == m_row[i];
  endfunction

  task automatic cmp(input string tag, input logic [2:0] eo, input logic [N-1:0] eg,
                     input logic [BW-1:0] eb, input logic [RW-1:0] er);
    checks++;
    if (op !== eo || gnt !== eg || bank !== eb || row !== er) begin
      errors++;
      $display("FAIL %s op=%0d gnt=%b bank=%0d row=%0d exp op=%0d gnt=%b bank=%0d row=%0d",
               tag, op, gnt, bank, row, eo, eg, eb, er);
    end
  endtask

  // Expected result per R2-R10 from the bench's own open-row table
  task automatic step(input string tag);
    int best = -1;
    logic [2:0] eo = 0;
    logic [N-1:0] eg = '0;
    logic [BW-1:0] eb = '0;
    logic [RW-1:0] er = '0;
    for (int i = 0; i < N; i++) begin
      if (!m_req[i]) continue;
      if (best < 0) best = i;
      else if (is_hit(i) && !is_hit(best)) best = i;
      else if (is_hit(i) == is_hit(best) && m_prio[i] > m_prio[best]) best = i;
      else if (is_hit(i) == is_hit(best) && m_prio[i] == m_prio[best]
               && older(m_age[i], m_age[best])) best = i;
    end
    if (best >= 0) begin
      eb = m_bank[best];
      er = m_row[best];
      if (is_hit(best)) begin
        eo = m_rd[best] ? 3'd3 : 3'd4;
        eg[best] = 1'b1;
      end else if (tv[eb]) begin
        eo = 3'd2;
        er = tr[eb];
        tv[eb] = 1'b0;
      end else begin
        eo = 3'd1;
        tv[eb] = 1'b1;
        tr[eb] = er;
      end
    end
    @(posedge clk);
    #1;
    if (tag == "") tag = (eo == 0) ? "R2" : (eo == 1) ? "R9" : (eo == 2) ? "R8" : "R7";
    cmp(tag, eo, eg, eb, er);
  endtask

  task automatic clr();
    for (int i = 0; i < N; i++) begin
      m_req[i] = 0; m_rd[i] = 0; m_bank[i] = 0; m_row[i] = 0; m_prio[i] = 0; m_age[i] = 0;
    end
  endtask

  task automatic put(input int i, input bit rd, input int b, input int r, input int p, input int a);
    m_req[i] = 1; m_rd[i] = rd; m_bank[i] = BW'(b); m_row[i] = RW'(r);
    m_prio[i] = PW'(p); m_age[i] = AW'(a);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    clr();
    for (int b = 0; b < NB; b++) begin tv[b] = 0; tr[b] = '0; end
    #12 rst_n = 1;
    @(posedge clk); #1;
    cmp("R1", 3'd0, '0, '0, '0);
    step("R2");
    // R1 / R9: bank closed after reset -> activate
    put(0, 1, 1, 5, 0, 10); step("R9");
    put(0, 1, 1, 5, 0, 10); step("R7");
    // R3: low-priority write hit beats high-priority read miss
    clr(); put(1, 0, 1, 5, 0, 20); put(2, 1, 2, 7, 7, 1); step("R3");
    // R4
    clr(); put(0, 1, 1, 5, 2, 1); put(3, 0, 1, 5, 5, 9); step("R4");
    // R5: stamp 250 older than 3 across wrap
    clr(); put(0, 1, 1, 5, 3, 250); put(1, 1, 1, 5, 3, 3); step("R5");
    clr(); put(0, 1, 1, 5, 3, 3); put(1, 1, 1, 5, 3, 250); step("R5");
    // R6
    clr(); put(1, 0, 1, 5, 4, 7); put(2, 1, 1, 5, 4, 7); step("R6");
    // R10: no hits -> priority then activate
    clr(); put(0, 1, 2, 1, 1, 0); put(1, 0, 3, 2, 4, 5); step("R10");
    clr(); put(0, 1, 2, 1, 6, 9); put(2, 0, 0, 2, 6, 4); step("R10");
    // R8: different row open in bank 1 -> precharge, activate, access
    clr(); put(0, 0, 1, 9, 0, 0); step("R8");
    step("R9");
    step("R7");
    clr(); step("R2");
    for (int c = 0; c < 400; c++) begin
      logic [AW-1:0] base = AW'($urandom);
      clr();
      if ($urandom % 8 != 0)
        for (int i = 0; i < N; i++)
          if ($urandom % 10 < 6)
            put(i, bit'($urandom), $urandom % NB, $urandom % 3, $urandom % 4,
                int'(base + AW'($urandom % 32)));
      step("");
    end
    finish_run();
  end
endmodule